// File: doc/BRIEF.md
# Front-Panel Access Controller

This block decides whether key presses from an instrument's front panel are allowed to reach the rest of the instrument. It is a three-state machine with the states LOCAL, REMOTE and LOCKOUT. In LOCAL, every panel key passes. In REMOTE, only the key that returns the panel to local control passes. In LOCKOUT, no key passes at all.

The state changes on three decoded command strobes: go-local, go-remote and lockout. Each strobe comes with a code that names the command interface it arrived on. Only commands tagged with the serial-port code change the state. The same commands from any other interface are dropped.

Inputs from the panel are a debounced local-key pulse and a raw key-valid strobe. Outputs are the present state, a gated key-valid strobe, and a flag that is high while the local key is the only key allowed through.

Transitions:
- LOCAL→REMOTE and LOCKOUT→REMOTE on go-remote.
- Any state→LOCKOUT on lockout.
- REMOTE→LOCAL and LOCKOUT→LOCAL on go-local.
- REMOTE→LOCAL on the local key.
- Each state stays where it is (a self-loop) when there is no qualified request.

Top module: `rc_access_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `state_o` reads LOCAL.
- R2: `state_o` uses these codes: LOCAL = 0, REMOTE = 1, LOCKOUT = 2.
- R3: A go-local strobe with `cmd_src_i` equal to the serial code (1) moves the state to LOCAL on the next clock edge.
- R4: A serial go-remote strobe moves the state to REMOTE. In REMOTE, `key_valid_o` equals `key_valid_i` AND `local_key_i`.
- R5: A serial lockout strobe moves the state to LOCKOUT. In LOCKOUT, `key_valid_o` is 0 whatever the panel inputs are.
- R6: A command strobe whose `cmd_src_i` is any code other than 1 leaves the state unchanged.
- R7: A local-key pulse in REMOTE, with no serial command in the same cycle, moves the state to LOCAL on the next edge.
- R8: A local-key pulse in LOCKOUT leaves the state in LOCKOUT.
- R9: When serial strobes arrive together, lockout wins over go-remote and go-remote wins over go-local. Any serial command wins over the local key.
- R10: `key_valid_o` depends only on the registered state. A key still passes during the cycle in which a blocking command is presented, and gating starts after the edge that registers the command.
- R11: In LOCAL, `key_valid_o` equals `key_valid_i`. `local_only_o` is 1 exactly when the state is REMOTE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_local_i | input | 1 | Go-local command strobe |
| cmd_remote_i | input | 1 | Go-remote command strobe |
| cmd_lock_i | input | 1 | Lockout command strobe |
| cmd_src_i | input | SRC_W (2) | Interface code of the command; 1 = serial |
| local_key_i | input | 1 | Debounced local-key pulse |
| key_valid_i | input | 1 | Raw panel key-valid strobe |
| state_o | output | 2 | Present access state |
| key_valid_o | output | 1 | Gated key-valid strobe |
| local_only_o | output | 1 | High when only the local key may pass |

## Verification
A wrong state register shows up at the ports in the cycle right after the faulty edge. `state_o` carries the wrong code, and `key_valid_o` and `local_only_o` take on the gating of the wrong state. This matters most for a dropped lockout or a local-key escape from lockout: either one lets panel keys pass in the next cycle that has `key_valid_i` high. Every vector therefore compares all three outputs one cycle after its stimulus is registered, so a bad transition is reported within one clock. Vectors that carry commands from other interfaces and simultaneous strobes expose faults in interface filtering and in priority.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [1:0] {
        ST_LOCAL   = 2'd0,
        ST_REMOTE  = 2'd1,
        ST_LOCKOUT = 2'd2
    } rc_state_e;

    typedef enum logic [1:0] {
        REQ_NONE   = 2'd0,
        REQ_LOCAL  = 2'd1,
        REQ_REMOTE = 2'd2,
        REQ_LOCK   = 2'd3
    } rc_req_e;

endpackage

// File: rtl/rc_cmd_filter.sv
module rc_cmd_filter
    import rc_pkg::*;
#(
    parameter int SRC_W      = 2,
    parameter int SERIAL_SRC = 1
) (
    input  logic             cmd_local_i,
    input  logic             cmd_remote_i,
    input  logic             cmd_lock_i,
    input  logic [SRC_W-1:0] cmd_src_i,
    output rc_req_e          req_o
);
    localparam logic [SRC_W-1:0] SERIAL_CODE = SRC_W'(SERIAL_SRC);

    logic from_serial;

    always_comb begin
        from_serial = (cmd_src_i == SERIAL_CODE);
        req_o = REQ_NONE;
        if (from_serial) begin
            if (cmd_lock_i)        req_o = REQ_LOCK;
            else if (cmd_remote_i) req_o = REQ_REMOTE;
            else if (cmd_local_i)  req_o = REQ_LOCAL;
        end
    end

    // R6: commands from any other interface never produce a request
    always_comb begin
        if (!from_serial)
            assert_foreign_dropped_R6: assert (req_o == REQ_NONE);
    end
endmodule

// File: rtl/rc_fsm.sv
module rc_fsm
    import rc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  rc_req_e   req_i,
    input  logic      local_key_i,
    output rc_state_e state_o
);
    rc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOCAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (req_i)
            REQ_LOCK:   state_d = ST_LOCKOUT;
            REQ_REMOTE: state_d = ST_REMOTE;
            REQ_LOCAL:  state_d = ST_LOCAL;
            REQ_NONE: begin
                unique case (state_q)
                    ST_LOCAL:   state_d = ST_LOCAL;
                    ST_REMOTE:  state_d = local_key_i ? ST_LOCAL : ST_REMOTE;
                    ST_LOCKOUT: state_d = ST_LOCKOUT;
                    default:    state_d = ST_LOCAL;
                endcase
            end
            default: state_d = state_q;
        endcase
    end

    assign state_o = state_q;

    assert_reset_local_R1: assert property (@(posedge clk)
        !rst_n |=> state_q == ST_LOCAL);

    assert_lock_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_i == REQ_LOCK |=> state_q == ST_LOCKOUT);

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOCKOUT && req_i == REQ_NONE) |=> state_q == ST_LOCKOUT);

    assert_key_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REMOTE && req_i == REQ_NONE && local_key_i) |=> state_q == ST_LOCAL);

    assert_legal_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'd3);
endmodule

// File: rtl/rc_key_gate.sv
module rc_key_gate
    import rc_pkg::*;
(
    input  rc_state_e state_i,
    input  logic      local_key_i,
    input  logic      key_valid_i,
    output logic      key_valid_o,
    output logic      local_only_o
);
    always_comb begin
        key_valid_o  = 1'b0;
        local_only_o = 1'b0;
        unique case (state_i)
            ST_LOCAL:   key_valid_o = key_valid_i;
            ST_REMOTE: begin
                key_valid_o  = key_valid_i & local_key_i;
                local_only_o = 1'b1;
            end
            ST_LOCKOUT: key_valid_o = 1'b0;
            default:    key_valid_o = 1'b0;
        endcase
    end

    // R5: in lockout nothing passes
    always_comb begin
        if (state_i == ST_LOCKOUT)
            assert_lock_blocks_R5: assert (!key_valid_o);
        if (!key_valid_i)
            assert_no_spurious_key_R4: assert (!key_valid_o);
    end
endmodule

// File: rtl/rc_access_ctrl.sv
module rc_access_ctrl
    import rc_pkg::*;
#(
    parameter int SRC_W      = 2,
    parameter int SERIAL_SRC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_local_i,
    input  logic             cmd_remote_i,
    input  logic             cmd_lock_i,
    input  logic [SRC_W-1:0] cmd_src_i,
    input  logic             local_key_i,
    input  logic             key_valid_i,
    output logic [1:0]       state_o,
    output logic             key_valid_o,
    output logic             local_only_o
);
    localparam logic [SRC_W-1:0] SERIAL_CODE = SRC_W'(SERIAL_SRC);

    rc_req_e   req;
    rc_state_e state;

    rc_cmd_filter #(.SRC_W(SRC_W), .SERIAL_SRC(SERIAL_SRC)) u_filter (
        .cmd_local_i  (cmd_local_i),
        .cmd_remote_i (cmd_remote_i),
        .cmd_lock_i   (cmd_lock_i),
        .cmd_src_i    (cmd_src_i),
        .req_o        (req)
    );

    rc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .local_key_i (local_key_i),
        .state_o     (state)
    );

    rc_key_gate u_gate (
        .state_i      (state),
        .local_key_i  (local_key_i),
        .key_valid_i  (key_valid_i),
        .key_valid_o  (key_valid_o),
        .local_only_o (local_only_o)
    );

    assign state_o = state;

    assert_foreign_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_src_i != SERIAL_CODE && !local_key_i) |=> $stable(state_o));

    assert_flag_remote_R11: assert property (@(posedge clk) disable iff (!rst_n)
        local_only_o == (state_o == 2'd1));
endmodule

// File: tb/tb_rc_access_ctrl.sv
module tb_rc_access_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_local_i = 1'b0, cmd_remote_i = 1'b0, cmd_lock_i = 1'b0;
    logic [1:0] cmd_src_i = 2'd0;
    logic       local_key_i = 1'b0, key_valid_i = 1'b0;
    logic [1:0] state_o;
    logic       key_valid_o, local_only_o;

    always #2 clk = ~clk;

    rc_access_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_local_i(cmd_local_i), .cmd_remote_i(cmd_remote_i), .cmd_lock_i(cmd_lock_i),
        .cmd_src_i(cmd_src_i), .local_key_i(local_key_i), .key_valid_i(key_valid_i),
        .state_o(state_o), .key_valid_o(key_valid_o), .local_only_o(local_only_o)
    );

    typedef struct {
        logic [1:0] st;
        logic       kv;
        logic       lo;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    logic [1:0] model_st = 2'd0;
    bit   done = 1'b0;

    // Driver: drive at negedge, push expected outputs for this cycle, advance model
    task automatic apply(input logic cl, input logic cr, input logic ck,
                         input logic [1:0] src, input logic lk, input logic kv,
                         input string tag);
        exp_t e;
        @(negedge clk);
        cmd_local_i = cl; cmd_remote_i = cr; cmd_lock_i = ck;
        cmd_src_i = src; local_key_i = lk; key_valid_i = kv;
        e.st  = model_st;
        e.kv  = kv && (model_st == 2'd0 || (model_st == 2'd1 && lk));
        e.lo  = (model_st == 2'd1);
        e.tag = tag;
        exp_q.push_back(e);
        if (src == 2'd1 && ck)       model_st = 2'd2;
        else if (src == 2'd1 && cr)  model_st = 2'd1;
        else if (src == 2'd1 && cl)  model_st = 2'd0;
        else if (model_st == 2'd1 && lk) model_st = 2'd0;
    endtask

    // Monitor: compare shortly after the driver, away from clock edges
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_vec++;
                if (state_o !== e.st || key_valid_o !== e.kv || local_only_o !== e.lo) begin
                    n_bad++;
                    $display("FAIL %s: got st=%0d kv=%0b lo=%0b, expected st=%0d kv=%0b lo=%0b",
                             e.tag, state_o, key_valid_o, local_only_o, e.st, e.kv, e.lo);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        n_vec++;
        if (state_o !== 2'd0) begin
            n_bad++;
            $display("FAIL R1: in reset got st=%0d, expected st=0", state_o);
        end
        rst_n = 1'b1;
        apply(0,0,0,2'd0,0,1,"R1 R11");      // first cycle: LOCAL, key passes
        apply(0,0,1,2'd1,0,1,"R10");          // lockout presented: key still passes
        apply(0,0,0,2'd0,0,1,"R5 R2");        // now LOCKOUT, code 2, blocked
        apply(0,0,0,2'd0,1,1,"R5");           // local key blocked too
        apply(0,0,0,2'd0,0,0,"R8");           // still LOCKOUT after local key
        apply(1,0,0,2'd0,0,0,"R6");           // local cmd from interface 0
        apply(1,0,0,2'd2,0,0,"R6");           // from interface 2
        apply(0,1,0,2'd3,0,0,"R6");           // remote cmd from interface 3
        apply(1,0,0,2'd1,0,0,"R6");           // still LOCKOUT; serial local issued
        apply(0,0,0,2'd0,0,1,"R3 R11");       // LOCAL, key passes
        apply(0,1,0,2'd2,0,1,"R6");           // foreign remote ignored in LOCAL
        apply(0,1,0,2'd1,0,1,"R10");          // serial remote; key passes this cycle
        apply(0,0,0,2'd0,0,1,"R4 R2 R11");    // REMOTE: plain key blocked
        apply(0,0,0,2'd0,1,1,"R4 R7");        // local key passes and exits
        apply(1,1,0,2'd1,0,0,"R7 R9");        // LOCAL; remote+local together
        apply(0,1,1,2'd1,0,0,"R9");           // REMOTE; lock+remote together
        apply(1,0,0,2'd1,0,0,"R9");           // LOCKOUT; serial local
        apply(0,1,0,2'd1,0,0,"R3");           // LOCAL; serial remote
        apply(0,1,0,2'd1,1,1,"R9");           // REMOTE; remote cmd beats local key
        apply(1,0,1,2'd1,0,0,"R9");           // still REMOTE; lock+local
        apply(0,0,0,2'd0,1,1,"R9 R8");        // LOCKOUT
        apply(0,0,0,2'd0,0,0,"R8");
        apply(0,0,0,2'd0,0,0,"R8");           // drain
        @(negedge clk);
        #2;
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule